// File: doc/BRIEF.md
# Splittable Eight-Input Logic Element

This block is one configurable logic element with eight data inputs and two function outputs. Its 128 bits of truth-table storage are split into a low half and a high half of 64 bits each. A three-bit mode code decides how the eight inputs are spread over the two halves. The storage can serve as two small independent tables, as one table of mixed sizes, as two tables that share some inputs, or as one six-input table. The same storage can also serve as two six-input copies of one table. A further mode bypasses the tables and routes the inputs through two chained full adders.

The truth tables are written one bit at a time through a configuration port. Writes are accepted only while the element is held in configuration state, and during that time its outputs stay at zero. Each output can deliver either its combinational result or the value held in its own register. The two registers share a clock, a clock enable and a synchronous reset.

Top module: `alm_cell`

## Requirements
- R1: While cfg_en_i is 1, a rising edge with cfg_we_i at 1 stores cfg_data_i into table bit cfg_addr_i. Addresses 0..63 select the low table L[0..63] and addresses 64..127 select the high table H[0..63]. A write strobe while cfg_en_i is 0 leaves the table unchanged.
- R2: Mode code 0 gives two four-input tables: out0 = L[din[3:0]] and out1 = H[din[7:4]].
- R3: Mode code 1 gives a three-input and a five-input table: out0 = L[din[2:0]] and out1 = H[din[7:3]].
- R4: Mode code 2 gives two five-input tables sharing din[1:0]: out0 = L[{din[4:2],din[1:0]}] and out1 = H[{din[7:5],din[1:0]}].
- R5: Mode code 3 gives one six-input table: out0 = L[din[5:0]] and out1 = 0.
- R6: Mode code 4 gives two six-input copies of the low table sharing din[3:0]: out0 = L[{din[5:4],din[3:0]}] and out1 = L[{din[7:6],din[3:0]}].
- R7: Mode code 5 is arithmetic. With A = {din[2],din[0]} and B = {din[3],din[1]}, the value {cout_o,out1,out0} equals A + B + cin_i.
- R8: Mode codes 6 and 7 give combinational results of 0. cout_o is 0 in every mode except code 5.
- R9: oreg_sel_i[i] = 0 presents the combinational result of output i on out_o[i]. oreg_sel_i[i] = 1 presents the register of output i instead.
- R10: A register loads its combinational result on a rising edge with ce_i at 1 and holds its value while ce_i is 0. rst_i at 1 clears both registers to 0 on the next edge, taking priority over ce_i.
- R11: While cfg_en_i is 1, the combinational results and cout_o are 0 and the registers do not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table and the output registers |
| rst_i | input | 1 | Synchronous active-high reset of the output registers |
| cfg_en_i | input | 1 | Holds the element in configuration state |
| cfg_we_i | input | 1 | Table bit write strobe |
| cfg_addr_i | input | 7 | Table bit address |
| cfg_data_i | input | 1 | Table bit value |
| mode_i | input | 3 | Input sharing mode code |
| oreg_sel_i | input | 2 | Per-output registered/combinational select |
| ce_i | input | 1 | Register clock enable |
| din_i | input | 8 | Data inputs |
| cin_i | input | 1 | Carry into the first adder |
| out_o | output | 2 | Function outputs |
| cout_o | output | 1 | Carry out of the second adder |

## Verification
Combinational results follow din_i, mode_i and cin_i in the same cycle. The bench therefore drives these inputs on the falling edge and compares a moment later, before any rising edge can intervene. A table write becomes visible on the rising edge that stores it, so lookups that depend on a write are checked only from the next falling edge onward. A registered output changes on the first rising edge with ce_i or rst_i high, and it is sampled on the following falling edge. Hold behaviour is checked across one or more edges with ce_i low after the data inputs have changed.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int IN_W      = 8;
    localparam int HALF_BITS = 64;
    localparam int CFG_AW    = $clog2(2 * HALF_BITS);
    localparam int MODE_W    = 3;
    localparam int N_OUT     = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_QUAD       = 3'd0,
        MD_TRI_PENTA  = 3'd1,
        MD_PENTA_PAIR = 3'd2,
        MD_HEXA       = 3'd3,
        MD_HEXA_TWIN  = 3'd4,
        MD_ARITH      = 3'd5,
        MD_RSV6       = 3'd6,
        MD_RSV7       = 3'd7
    } alm_mode_e;

    typedef struct packed {
        logic             cout;
        logic [N_OUT-1:0] f;
    } alm_res_t;

    // returns {carry, sum}
    function automatic logic [1:0] full_add(input logic a, input logic b, input logic c);
        full_add = {(a & b) | (a & c) | (b & c), a ^ b ^ c};
    endfunction
endpackage

// File: rtl/alm_cfg_store.sv
module alm_cfg_store
    import alm_pkg::*;
#(
    parameter int HB = HALF_BITS,
    localparam int AW = $clog2(2 * HB)
) (
    input  logic          clk,
    input  logic          cfg_en,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic          cfg_data,
    output logic [HB-1:0] lo_tab,
    output logic [HB-1:0] hi_tab
);
    logic [HB-1:0] lo_q;
    logic [HB-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (cfg_en && cfg_we) begin
            if (cfg_addr[AW-1])
                hi_q[cfg_addr[AW-2:0]] <= cfg_data;
            else
                lo_q[cfg_addr[AW-2:0]] <= cfg_data;
        end
    end

    assign lo_tab = lo_q;
    assign hi_tab = hi_q;
endmodule

// File: rtl/alm_lut_mux.sv
module alm_lut_mux
    import alm_pkg::*;
#(
    parameter int HB = HALF_BITS
) (
    input  alm_mode_e       mode,
    input  logic [IN_W-1:0] din,
    input  logic            cin,
    input  logic            hold,
    input  logic [HB-1:0]   lo_tab,
    input  logic [HB-1:0]   hi_tab,
    output alm_res_t        res
);
    logic [1:0] add0;
    logic [1:0] add1;

    always_comb begin
        add0 = full_add(din[0], din[1], cin);
        add1 = full_add(din[2], din[3], add0[1]);
        res  = '0;
        if (!hold) begin
            unique case (mode)
                MD_QUAD: begin
                    res.f[0] = lo_tab[din[3:0]];
                    res.f[1] = hi_tab[din[7:4]];
                end
                MD_TRI_PENTA: begin
                    res.f[0] = lo_tab[din[2:0]];
                    res.f[1] = hi_tab[din[7:3]];
                end
                MD_PENTA_PAIR: begin
                    res.f[0] = lo_tab[{din[4:2], din[1:0]}];
                    res.f[1] = hi_tab[{din[7:5], din[1:0]}];
                end
                MD_HEXA: begin
                    res.f[0] = lo_tab[din[5:0]];
                end
                MD_HEXA_TWIN: begin
                    res.f[0] = lo_tab[{din[5:4], din[3:0]}];
                    res.f[1] = lo_tab[{din[7:6], din[3:0]}];
                end
                MD_ARITH: begin
                    res.f[0] = add0[0];
                    res.f[1] = add1[0];
                    res.cout = add1[1];
                end
                default: res = '0;
            endcase
        end
    end
endmodule

// File: rtl/alm_out_regs.sv
module alm_out_regs
    import alm_pkg::*;
#(
    parameter int NO = N_OUT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          hold,
    input  logic [NO-1:0] sel,
    input  logic [NO-1:0] comb,
    output logic [NO-1:0] q,
    output logic [NO-1:0] dout
);
    for (genvar i = 0; i < NO; i++) begin : g_out
        logic q_r;
        always_ff @(posedge clk) begin
            if (rst)
                q_r <= 1'b0;
            else if (ce && !hold)
                q_r <= comb[i];
        end
        assign q[i]    = q_r;
        assign dout[i] = sel[i] ? q_r : comb[i];
    end
endmodule

// File: rtl/alm_cell.sv
module alm_cell
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_i,
    input  logic              cfg_en_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic              cfg_data_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [N_OUT-1:0]  oreg_sel_i,
    input  logic              ce_i,
    input  logic [IN_W-1:0]   din_i,
    input  logic              cin_i,
    output logic [N_OUT-1:0]  out_o,
    output logic              cout_o
);
    logic [HALF_BITS-1:0] lo_tab;
    logic [HALF_BITS-1:0] hi_tab;
    alm_res_t             res;
    logic [N_OUT-1:0]     reg_q;

    alm_cfg_store #(.HB(HALF_BITS)) u_store (
        .clk      (clk),
        .cfg_en   (cfg_en_i),
        .cfg_we   (cfg_we_i),
        .cfg_addr (cfg_addr_i),
        .cfg_data (cfg_data_i),
        .lo_tab   (lo_tab),
        .hi_tab   (hi_tab)
    );

    alm_lut_mux #(.HB(HALF_BITS)) u_mux (
        .mode   (alm_mode_e'(mode_i)),
        .din    (din_i),
        .cin    (cin_i),
        .hold   (cfg_en_i),
        .lo_tab (lo_tab),
        .hi_tab (hi_tab),
        .res    (res)
    );

    alm_out_regs #(.NO(N_OUT)) u_regs (
        .clk  (clk),
        .rst  (rst_i),
        .ce   (ce_i),
        .hold (cfg_en_i),
        .sel  (oreg_sel_i),
        .comb (res.f),
        .q    (reg_q),
        .dout (out_o)
    );

    assign cout_o = res.cout;
endmodule

// File: rtl/alm_cell_chk.sv
module alm_cell_chk (
    input logic       clk,
    input logic       rst_i,
    input logic       cfg_en_i,
    input logic       ce_i,
    input logic [2:0] mode_i,
    input logic [1:0] oreg_sel_i,
    input logic [7:0] din_i,
    input logic       cin_i,
    input logic [1:0] out_o,
    input logic       cout_o,
    input logic [1:0] reg_q
);
    assert_arith_sum_R7: assert property (@(posedge clk) disable iff (rst_i)
        (!cfg_en_i && mode_i == 3'd5 && oreg_sel_i == 2'b00) |->
        ({cout_o, out_o} == ({1'b0, din_i[2], din_i[0]} + {1'b0, din_i[3], din_i[1]} + {2'b00, cin_i})));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst_i)
        (!cfg_en_i && mode_i >= 3'd6 && oreg_sel_i == 2'b00) |-> (out_o == 2'b00 && !cout_o));

    assert_cout_idle_R8: assert property (@(posedge clk) disable iff (rst_i)
        (mode_i != 3'd5) |-> !cout_o);

    assert_reg_hold_R10: assert property (@(posedge clk) disable iff (rst_i)
        (!ce_i || cfg_en_i) |=> $stable(reg_q));

    assert_cfg_quiet_R11: assert property (@(posedge clk) disable iff (rst_i)
        (cfg_en_i && oreg_sel_i == 2'b00) |-> (out_o == 2'b00 && !cout_o));
endmodule

bind alm_cell alm_cell_chk u_chk (
    .clk        (clk),
    .rst_i      (rst_i),
    .cfg_en_i   (cfg_en_i),
    .ce_i       (ce_i),
    .mode_i     (mode_i),
    .oreg_sel_i (oreg_sel_i),
    .din_i      (din_i),
    .cin_i      (cin_i),
    .out_o      (out_o),
    .cout_o     (cout_o),
    .reg_q      (reg_q)
);

// File: tb/alm_cell_tb.sv
module alm_cell_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] LO_TAB = 64'h6A3C_F018_9B5E_2D47;
    localparam logic [63:0] HI_TAB = 64'hC1D3_5E87_0FA9_462B;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       cfg_en_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [6:0] cfg_addr_i = '0;
    logic       cfg_data_i = 1'b0;
    logic [2:0] mode_i = '0;
    logic [1:0] oreg_sel_i = '0;
    logic       ce_i = 1'b0;
    logic [7:0] din_i = '0;
    logic       cin_i = 1'b0;
    logic [1:0] out_o;
    logic       cout_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alm_cell u_dut (
        .clk(clk), .rst_i(rst_i), .cfg_en_i(cfg_en_i), .cfg_we_i(cfg_we_i),
        .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i), .mode_i(mode_i),
        .oreg_sel_i(oreg_sel_i), .ce_i(ce_i), .din_i(din_i), .cin_i(cin_i),
        .out_o(out_o), .cout_o(cout_o)
    );

    // expected {cout, out1, out0}
    function automatic logic [2:0] model(input logic [2:0] m, input logic [7:0] d, input logic c);
        logic [2:0] s;
        case (m)
            3'd0: model = {1'b0, HI_TAB[d[7:4]], LO_TAB[d[3:0]]};
            3'd1: model = {1'b0, HI_TAB[d[7:3]], LO_TAB[d[2:0]]};
            3'd2: model = {1'b0, HI_TAB[{d[7:5], d[1:0]}], LO_TAB[{d[4:2], d[1:0]}]};
            3'd3: model = {2'b00, LO_TAB[d[5:0]]};
            3'd4: model = {1'b0, LO_TAB[{d[7:6], d[3:0]}], LO_TAB[{d[5:4], d[3:0]}]};
            3'd5: begin
                s = {1'b0, d[2], d[0]} + {1'b0, d[3], d[1]} + {2'b00, c};
                model = s;
            end
            default: model = 3'b000;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (mode=%0d din=%h cin=%b)", req, act, exp, mode_i, din_i, cin_i);
        end
    endtask

    task automatic cfg_write(input logic en, input logic [6:0] a, input logic v);
        @(negedge clk);
        cfg_en_i = en; cfg_we_i = 1'b1; cfg_addr_i = a; cfg_data_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        string tag;
        repeat (2) @(negedge clk);
        rst_i = 1'b0;
        oreg_sel_i = 2'b11;
        #1 check("R10 reset", {1'b0, out_o}, 3'b000);

        // R1: load tables serially while in configuration state
        for (int k = 0; k < 128; k++)
            cfg_write(1'b1, 7'(k), k < 64 ? LO_TAB[k] : HI_TAB[k-64]);
        // R11: while configuring, outputs stay zero
        oreg_sel_i = 2'b00; mode_i = 3'd5; din_i = 8'hFF; cin_i = 1'b1;
        #1 check("R11 cfg quiet", {cout_o, out_o}, 3'b000);
        @(negedge clk);
        cfg_en_i = 1'b0;
        // R1: strobes outside configuration state are ignored
        cfg_write(1'b0, 7'd5, ~LO_TAB[5]);
        cfg_write(1'b0, 7'd69, ~HI_TAB[5]);
        mode_i = 3'd1; din_i = {5'd5, 3'd5};
        #1 check("R1 ignored write", {cout_o, out_o}, {1'b0, HI_TAB[5], LO_TAB[5]});

        // R2..R8: full sweep of modes, inputs and carry
        for (int m = 0; m < 8; m++) begin
            case (m)
                0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5";
                4: tag = "R6"; 5: tag = "R7"; default: tag = "R8";
            endcase
            for (int d = 0; d < 256; d++) begin
                for (int c = 0; c < 2; c++) begin
                    @(negedge clk);
                    mode_i = 3'(m); din_i = 8'(d); cin_i = 1'(c);
                    #1 check(tag, {cout_o, out_o}, model(3'(m), 8'(d), 1'(c)));
                end
            end
        end

        // R9/R10: registered outputs
        oreg_sel_i = 2'b11; mode_i = 3'd0;
        for (int d = 0; d < 256; d += 37) begin
            @(negedge clk);
            din_i = 8'(d); ce_i = 1'b1;
            @(negedge clk);
            ce_i = 1'b0;
            #1 check("R9 registered", {1'b0, out_o}, {1'b0, model(3'd0, 8'(d), 1'b0) & 3'b011});
            din_i = ~din_i;
            repeat (2) @(negedge clk);
            #1 check("R10 hold", {1'b0, out_o}, {1'b0, model(3'd0, 8'(d), 1'b0) & 3'b011});
        end
        // R9: mixed selection, out0 combinational, out1 registered
        oreg_sel_i = 2'b10; din_i = 8'h3C;
        #1 check("R9 mixed", {1'b0, out_o[0]}, {1'b0, LO_TAB[4'hC]});
        // R11: registers do not load while configuring
        oreg_sel_i = 2'b11;
        @(negedge clk);
        din_i = 8'hA5; ce_i = 1'b1;
        @(negedge clk);
        #1 check("R10 load", {1'b0, out_o}, {1'b0, HI_TAB[4'hA], LO_TAB[4'h5]});
        din_i = 8'h5A; cfg_en_i = 1'b1;
        @(negedge clk);
        #1 check("R11 no load", {1'b0, out_o}, {1'b0, HI_TAB[4'hA], LO_TAB[4'h5]});
        cfg_en_i = 1'b0;
        // R10: reset wins over clock enable
        mode_i = 3'd5; din_i = 8'h0F; cin_i = 1'b1; ce_i = 1'b1; rst_i = 1'b1;
        @(negedge clk);
        rst_i = 1'b0; ce_i = 1'b0;
        #1 check("R10 reset priority", {1'b0, out_o}, 3'b000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule